// File: doc/BRIEF.md
# Battery-Level Interrupt and Clock-Hint Controller

This block watches four active-low battery-level pins and one external-power pin. It turns changes on the first battery level into a system-management interrupt request. It also produces two hints for a power manager. The first forces the CPU clock to its slow rate. The second keeps the CPU clock running while an interrupt is being serviced.

Software reaches the block through a byte-wide indexed register port with index, read strobe, write strobe and data buses. Read data is combinational and valid while the read strobe is high. The strobe is consumed at the next rising edge. The interrupt handler proceeds as follows:
- It reads the source register to identify the cause. That read also re-arms the detector for the opposite pin level.
- It writes the status register to drop the request.
- It writes the source register, so that the clock hint falls at the next refresh tick.

Two state machines hold the control state.

The level detector has four states:
- `DET_ARM_LO`: waiting for a low level on level 1.
- `DET_HELD_LO`: a low level was latched.
- `DET_ARM_HI`: waiting for a high level.
- `DET_HELD_HI`: a high level was latched.

The detector moves as follows:
- *arm→held* when the interrupt is enabled and the synchronized level matches the armed level.
- *held→arm(opposite)* on a read of index A5h.

The clock-hint machine has three states:
- `CK_OFF`: no hint.
- `CK_HOLD`: the clock is held on.
- `CK_DRAIN`: a release has been written and the machine waits for a refresh tick.

It moves as follows:
- *any→CK_HOLD* on a detector latch event.
- *CK_HOLD→CK_DRAIN* on a write to A5h.
- *CK_DRAIN→CK_OFF* on `refresh_tick_i`.

Top module: `batt_smi_ctrl`

## Requirements
- R1: Every pin passes through two flops before use. A read of index A3h returns the synchronized battery levels in bits [3:0]: bit 0 is level 1 and bit 3 is level 4. A read returns 1 for high. All other bits read 0.
- R2: Index 82h bit 5 is the interrupt enable and index AFh bit 5 is the slow-clock enable. Both read back in bit 5 with all other bits 0. Unmapped indices, and any cycle without a read strobe, read 0x00.
- R3: `slow_clk_req_o` is high exactly when the slow-clock enable is set, synchronized level 1 is 0 and synchronized external power is 0.
- R4: With the interrupt enable clear, no interrupt is raised. Setting the enable while the armed level is present raises the interrupt.
- R5: After reset the detector is armed for level 1 = 0. A 1→0 change on level 1 sets `smi_req_o` at the third rising edge after the pin change.
- R6: A read of A5h returns bit 0 = 1 while a level is latched. Such a read clears the latch and arms the detector for the opposite level, so every change of level 1 raises an interrupt.
- R7: While a level is latched, level 1 is ignored. A new change raises no request until an A5h read clears the latch.
- R8: A write of any value to index A2h clears `smi_req_o`.
- R9: `clk_on_req_o` rises together with every interrupt. A refresh tick without a prior A5h write leaves it set. It falls at the first `refresh_tick_i` after a write to A5h.
- R10: After reset all outputs are 0, both enables are 0, the latch is clear and the synchronizers hold levels high and external power low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bl_n_i | input | 4 | Battery-level pins, 0 = low battery |
| ext_pwr_i | input | 1 | External power present when 1 |
| refresh_tick_i | input | 1 | One-cycle refresh pulse |
| reg_idx_i | input | 8 | Register index |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid while the read strobe is high |
| smi_req_o | output | 1 | Interrupt request |
| slow_clk_req_o | output | 1 | Force-slow-clock request |
| clk_on_req_o | output | 1 | Keep-CPU-clock-on request |

## Verification
A detector stuck in a held state shows at the ports as a missing interrupt when level 1 next changes. It also shows in bit 0 of an A5h read, which stays at 1 after the read that should have cleared it. Both symptoms are visible within three edges. A detector that flips polarity wrongly either re-raises the request while the level is unchanged or stays silent after a change; the bench checks both cases a few cycles after each pin change. A clock-hint machine in the wrong state shows as `clk_on_req_o` falling on a refresh tick that had no release written before it, or staying high after a refresh tick that followed a release. Each such case is checked in the cycle after the tick.

// File: rtl/batt_pkg.sv
package batt_pkg;
    localparam int NUM_LVL = 4;
    localparam int REG_W   = 8;

    localparam logic [REG_W-1:0] IDX_EN    = 8'h82;
    localparam logic [REG_W-1:0] IDX_CLR   = 8'hA2;
    localparam logic [REG_W-1:0] IDX_LVL   = 8'hA3;
    localparam logic [REG_W-1:0] IDX_SRC   = 8'hA5;
    localparam logic [REG_W-1:0] IDX_CTL   = 8'hAF;

    localparam int EN_BIT  = 5;
    localparam int SRC_BIT = 0;

    typedef enum logic [1:0] {
        DET_ARM_LO  = 2'd0,
        DET_HELD_LO = 2'd1,
        DET_ARM_HI  = 2'd2,
        DET_HELD_HI = 2'd3
    } det_state_t;

    typedef enum logic [1:0] {
        CK_OFF   = 2'd0,
        CK_HOLD  = 2'd1,
        CK_DRAIN = 2'd2
    } ck_state_t;
endpackage

// File: rtl/batt_sync.sv
module batt_sync #(
    parameter int          WIDTH   = 5,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= RST_VAL[g];
                stage2[g] <= RST_VAL[g];
            end else begin
                stage1[g] <= d_i[g];
                stage2[g] <= stage1[g];
            end
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/batt_bl1_det.sv
module batt_bl1_det
    import batt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic en_i,
    input  logic src_rd_i,
    output logic evt_o,
    output logic held_o
);
    det_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DET_ARM_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        evt_o   = 1'b0;
        held_o  = 1'b0;
        unique case (state_q)
            DET_ARM_LO: begin
                if (en_i && !lvl_i) begin
                    state_d = DET_HELD_LO;
                    evt_o   = 1'b1;
                end
            end
            DET_HELD_LO: begin
                held_o = 1'b1;
                if (src_rd_i) state_d = DET_ARM_HI;
            end
            DET_ARM_HI: begin
                if (en_i && lvl_i) begin
                    state_d = DET_HELD_HI;
                    evt_o   = 1'b1;
                end
            end
            DET_HELD_HI: begin
                held_o = 1'b1;
                if (src_rd_i) state_d = DET_ARM_LO;
            end
            default: state_d = DET_ARM_LO;
        endcase
    end
endmodule

// File: rtl/batt_clkon_fsm.sv
module batt_clkon_fsm
    import batt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic src_wr_i,
    input  logic refresh_i,
    output logic clk_on_o
);
    ck_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CK_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_OFF:   if (evt_i) state_d = CK_HOLD;
            CK_HOLD:  if (evt_i) state_d = CK_HOLD;
                      else if (src_wr_i) state_d = CK_DRAIN;
            CK_DRAIN: if (evt_i) state_d = CK_HOLD;
                      else if (refresh_i) state_d = CK_OFF;
            default:  state_d = CK_OFF;
        endcase
    end

    always_comb begin
        clk_on_o = 1'b0;
        unique case (state_q)
            CK_OFF:   clk_on_o = 1'b0;
            CK_HOLD:  clk_on_o = 1'b1;
            CK_DRAIN: clk_on_o = 1'b1;
            default:  clk_on_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/batt_regs.sv
module batt_regs
    import batt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   idx_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [NUM_LVL-1:0] lvl_i,
    input  logic               ext_i,
    input  logic               held_i,
    input  logic               evt_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic               smi_en_o,
    output logic               slow_req_o,
    output logic               smi_req_o,
    output logic               src_rd_o,
    output logic               src_wr_o
);
    logic smi_en_q, slow_en_q, smi_q;
    logic wr_en, wr_ctl, wr_clr;

    assign wr_en    = wr_i && (idx_i == IDX_EN);
    assign wr_ctl   = wr_i && (idx_i == IDX_CTL);
    assign wr_clr   = wr_i && (idx_i == IDX_CLR);
    assign src_rd_o = rd_i && (idx_i == IDX_SRC);
    assign src_wr_o = wr_i && (idx_i == IDX_SRC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_en_q  <= 1'b0;
            slow_en_q <= 1'b0;
            smi_q     <= 1'b0;
        end else begin
            if (wr_en)  smi_en_q  <= wdata_i[EN_BIT];
            if (wr_ctl) slow_en_q <= wdata_i[EN_BIT];
            if (evt_i)       smi_q <= 1'b1;
            else if (wr_clr) smi_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (idx_i)
                IDX_LVL: rdata_o[NUM_LVL-1:0] = lvl_i;
                IDX_EN:  rdata_o[EN_BIT]      = smi_en_q;
                IDX_CTL: rdata_o[EN_BIT]      = slow_en_q;
                IDX_SRC: rdata_o[SRC_BIT]     = held_i;
                default: rdata_o = '0;
            endcase
        end
    end

    assign smi_en_o   = smi_en_q;
    assign smi_req_o  = smi_q;
    assign slow_req_o = slow_en_q && !lvl_i[0] && !ext_i;
endmodule

// File: rtl/batt_smi_ctrl.sv
module batt_smi_ctrl
    import batt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] bl_n_i,
    input  logic               ext_pwr_i,
    input  logic               refresh_tick_i,
    input  logic [REG_W-1:0]   reg_idx_i,
    input  logic               reg_rd_i,
    input  logic               reg_wr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               smi_req_o,
    output logic               slow_clk_req_o,
    output logic               clk_on_req_o
);
    localparam int SYNC_W = NUM_LVL + 1;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, {NUM_LVL{1'b1}}};

    logic [SYNC_W-1:0]  pins_s;
    logic [NUM_LVL-1:0] lvl_s;
    logic               ext_s;
    logic               smi_en, evt, held, src_rd, src_wr;

    batt_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({ext_pwr_i, bl_n_i}), .q_o(pins_s)
    );

    assign lvl_s = pins_s[NUM_LVL-1:0];
    assign ext_s = pins_s[NUM_LVL];

    batt_bl1_det u_det (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_s[0]), .en_i(smi_en),
        .src_rd_i(src_rd), .evt_o(evt), .held_o(held)
    );

    batt_clkon_fsm u_ck (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .src_wr_i(src_wr),
        .refresh_i(refresh_tick_i), .clk_on_o(clk_on_req_o)
    );

    batt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .idx_i(reg_idx_i), .rd_i(reg_rd_i),
        .wr_i(reg_wr_i), .wdata_i(reg_wdata_i), .lvl_i(lvl_s), .ext_i(ext_s),
        .held_i(held), .evt_i(evt), .rdata_o(reg_rdata_o), .smi_en_o(smi_en),
        .slow_req_o(slow_clk_req_o), .smi_req_o(smi_req_o),
        .src_rd_o(src_rd), .src_wr_o(src_wr)
    );
endmodule

// File: rtl/batt_smi_ctrl_chk.sv
module batt_smi_ctrl_chk
    import batt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             smi_req,
    input logic             clk_on,
    input logic             refresh,
    input logic             wr,
    input logic [REG_W-1:0] idx,
    input logic             smi_en
);
    // R4
    smi_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> $past(smi_en));

    // R9
    clkon_with_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> clk_on);

    // R8
    smi_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_req) |-> $past(wr && idx == IDX_CLR));

    // R9
    clkon_drop_on_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_on) |-> $past(refresh));
endmodule

bind batt_smi_ctrl batt_smi_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req_o), .clk_on(clk_on_req_o),
    .refresh(refresh_tick_i), .wr(reg_wr_i), .idx(reg_idx_i), .smi_en(smi_en)
);

// File: tb/batt_smi_ctrl_tb.sv
module batt_smi_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bl_n = 4'hF;
    logic       ext_pwr = 1'b0;
    logic       refresh = 1'b0;
    logic [7:0] idx = 8'h00;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       smi, slow, clk_on;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    batt_smi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bl_n_i(bl_n), .ext_pwr_i(ext_pwr),
        .refresh_tick_i(refresh), .reg_idx_i(idx), .reg_rd_i(rd), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .smi_req_o(smi),
        .slow_clk_req_o(slow), .clk_on_req_o(clk_on)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic rreg(input logic [7:0] a, output logic [7:0] v);
        idx = a; rd = 1'b1;
        #1 v = rdata;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        idx = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic tick();
        refresh = 1'b1;
        @(posedge clk);
        @(negedge clk);
        refresh = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        // R10 reset state
        chk("R10 smi", {7'd0, smi}, 8'd0);
        chk("R10 clk_on", {7'd0, clk_on}, 8'd0);
        chk("R10 slow", {7'd0, slow}, 8'd0);
        rreg(8'h82, v); chk("R10 en", v, 8'h00);
        rreg(8'hAF, v); chk("R10 ctl", v, 8'h00);
        rreg(8'hA5, v); chk("R10 src", v, 8'h00);
        rreg(8'hA3, v); chk("R10 lvl", v, 8'h0F);
        // R2 readback masks and unmapped index
        wreg(8'hAF, 8'hFF);
        rreg(8'hAF, v); chk("R2 ctl", v, 8'h20);
        rreg(8'h10, v); chk("R2 unmapped", v, 8'h00);
        chk("R2 no strobe", rdata, 8'h00);
        // R1 / R3 sweep: slow enable x ext power x levels, interrupt disabled
        for (int s = 0; s < 2; s++) begin
            wreg(8'hAF, s[0] ? 8'h20 : 8'h00);
            for (int e = 0; e < 2; e++) begin
                for (int b = 0; b < 16; b++) begin
                    bl_n = b[3:0]; ext_pwr = e[0];
                    cyc(3);
                    rreg(8'hA3, v);
                    chk("R1 lvl", v, {4'h0, b[3:0]});
                    chk("R3 slow", {7'd0, slow},
                        {7'd0, s[0] & ~b[0] & ~e[0]});
                end
            end
        end
        chk("R4 no smi while disabled", {7'd0, smi}, 8'd0);
        bl_n = 4'hF; ext_pwr = 1'b0;
        wreg(8'hAF, 8'h00);
        cyc(3);
        wreg(8'h82, 8'h20);
        rreg(8'h82, v); chk("R2 en", v, 8'h20);
        cyc(3);
        chk("R5 idle high", {7'd0, smi}, 8'd0);
        // R5 latency: third edge after the change
        bl_n[0] = 1'b0;
        cyc(2);
        chk("R5 before", {7'd0, smi}, 8'd0);
        cyc(1);
        chk("R5 after", {7'd0, smi}, 8'd1);
        chk("R9 clk_on with smi", {7'd0, clk_on}, 8'd1);
        // R6 source read and re-arm
        rreg(8'hA5, v); chk("R6 src set", v, 8'h01);
        rreg(8'hA5, v); chk("R6 src cleared", v, 8'h00);
        chk("R6 no retrigger on same level", {7'd0, smi}, 8'd1);
        // R8 clear
        wreg(8'hA2, 8'h00);
        chk("R8 cleared", {7'd0, smi}, 8'd0);
        chk("R9 still on", {7'd0, clk_on}, 8'd1);
        // R9 refresh without release write
        tick();
        chk("R9 tick w/o write", {7'd0, clk_on}, 8'd1);
        wreg(8'hA5, 8'h00);
        chk("R9 after write", {7'd0, clk_on}, 8'd1);
        cyc(2);
        chk("R9 waits for tick", {7'd0, clk_on}, 8'd1);
        tick();
        chk("R9 dropped", {7'd0, clk_on}, 8'd0);
        // R6 opposite edge
        bl_n[0] = 1'b1;
        cyc(4);
        chk("R6 rising change", {7'd0, smi}, 8'd1);
        chk("R9 on again", {7'd0, clk_on}, 8'd1);
        // R7 ignored while held
        wreg(8'hA2, 8'h00);
        bl_n[0] = 1'b0;
        cyc(4);
        chk("R7 ignored", {7'd0, smi}, 8'd0);
        rreg(8'hA5, v); chk("R7 still held", v, 8'h01);
        cyc(2);
        chk("R7 retrigger after read", {7'd0, smi}, 8'd1);
        // R4 disable, then enable with level present
        wreg(8'h82, 8'h00);
        rreg(8'hA5, v);
        wreg(8'hA2, 8'h00);
        bl_n[0] = 1'b1;
        cyc(4);
        chk("R4 disabled", {7'd0, smi}, 8'd0);
        wreg(8'h82, 8'h20);
        cyc(2);
        chk("R4 enable triggers", {7'd0, smi}, 8'd1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule